// File: doc/BRIEF.md
# Multi-Mode Sequential Divider

This block divides a dividend by a 16-bit divisor over a fixed sequence of clock steps and returns a 16-bit quotient and a 16-bit remainder. It handles five kinds of operand: unsigned and two's-complement integers with a 32-bit dividend, unsigned and two's-complement integers with a 16-bit dividend, and Q15 fractions with a 16-bit dividend. Every mode uses the same datapath and the same number of steps. A 16-bit integer dividend is widened to 32 bits by zero or sign extension in the first step. A Q15 dividend is scaled up by 2^15 so that the integer quotient comes out in Q15.

A host pulses `start` with a mode code and operands while the block is idle. The block then raises `busy` and works through 18 steps. On the last step it drops `busy` and pulses `done` for one cycle, with the results and the error flag. A `hold` input stalls the sequence between steps, for example while the surrounding pipeline takes an interrupt. Releasing `hold` resumes the operation from where it stopped.

Top module: `stepwise_divider`

## Requirements
- R1: The mode code selects the operation: 3'b000 is Q15 fractional, 3'b001 is signed with a 32-bit dividend, 3'b010 is unsigned with a 32-bit dividend, 3'b011 is signed with a 16-bit dividend, and 3'b100 is unsigned with a 16-bit dividend. In every mode the quotient appears on `quotient` and the remainder on `remainder`.
- R2: In fractional mode, `dividend[15:0]` and `divisor` are Q15 values. The quotient is trunc(a*2^15/b) in Q15, and the remainder is the matching integer remainder.
- R3: In the 32-bit modes the full `dividend` is used, with bits 31:16 as the upper word.
- R4: In the 16-bit modes only `dividend[15:0]` is used, sign-extended for 3'b011 and zero-extended for 3'b100. Bits 31:16 have no effect on the results.
- R5: Signed modes round the quotient toward zero. The remainder takes the sign of the dividend and has a smaller magnitude than the divisor.
- R6: A start pulse taken while idle with a legal code raises `busy` in the next cycle. If `hold` stays low, `busy` falls and `done` rises 18 clock edges after the edge that took `start`.
- R7: Each edge at which `hold` is high while `busy` is high adds exactly one cycle before `done`, and leaves the results the same as an unstalled run.
- R8: A start pulse while `busy` is high is ignored: the operation in progress completes with its original operands and timing.
- R9: `done` is high for exactly one cycle per operation. `quotient`, `remainder` and `err` change only at the edge that raises `done`, or at an accepted start (where `err` clears), and otherwise stay stable.
- R10: A zero divisor, or a quotient outside -32768..32767 (signed and fractional modes) or 0..65535 (unsigned modes), raises `err` together with `done`. The quotient and remainder are then unspecified.
- R11: A start with a code from 3'b101 to 3'b111 never raises `busy`. It gives `done` and `err` high in the next cycle and leaves `quotient` and `remainder` unchanged.
- R12: A synchronous active-low reset clears `busy`, `done` and `err`, and sets `quotient` and `remainder` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 3 | Operation code |
| dividend | input | 32 | Dividend; low half only in 16-bit and fractional modes |
| divisor | input | 16 | Divisor |
| hold | input | 1 | Stall the sequence between steps |
| quotient | output | 16 | Quotient of the last operation |
| remainder | output | 16 | Remainder of the last operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error of the last operation (overflow, zero divisor, illegal code) |

## Verification
The hardest situations to reach from the ports combine a stall with other events. One is a stall on the very last step, when `done` is about to rise. Another is a new start pulse arriving during a stall. Operations are therefore run with stall patterns indexed by the step number, including patterns that stall on the first and on the final step. Some runs also drive a start with different operands in the middle of a stalled sequence, and the cycle-level reference model must show that the stall and the stray start change nothing except the finishing cycle.

// File: rtl/sdiv_pkg.sv
// Package: shared mode codes and mode classification helpers for the
// sequential divider. Assumes a 3-bit mode code.
package sdiv_pkg;

    typedef enum logic [2:0] {
        MD_FRAC = 3'b000,
        MD_S32  = 3'b001,
        MD_U32  = 3'b010,
        MD_S16  = 3'b011,
        MD_U16  = 3'b100
    } div_mode_e;

    // Codes above the last defined mode are rejected.
    function automatic logic mode_legal(input logic [2:0] m);
        return m <= 3'd4;
    endfunction

    // Modes that treat operands as two's complement.
    function automatic logic mode_signed(input logic [2:0] m);
        return (m == MD_FRAC) || (m == MD_S32) || (m == MD_S16);
    endfunction

endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: widens the dividend according to the mode,
// takes magnitudes of signed operands, records the result signs and
// flags a zero divisor or a quotient that cannot fit W bits.
// Assumes the mode code is legal; combinational only.
module sdiv_prep import sdiv_pkg::*; #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] raw_a,
    input  logic [W-1:0]   raw_b,
    input  logic [2:0]     mode,
    output logic [2*W-1:0] a_mag,
    output logic [W-1:0]   b_mag,
    output logic           neg_q,
    output logic           neg_r,
    output logic           is_signed,
    output logic           early_err
);
    logic [2*W-1:0] a_ext;
    logic           a_neg, b_neg;

    // Form the 2W-bit dividend for the selected mode.
    always_comb begin
        case (mode)
            MD_FRAC: a_ext = {raw_a[W-1], raw_a[W-1:0], {(W-1){1'b0}}};
            MD_S16:  a_ext = {{W{raw_a[W-1]}}, raw_a[W-1:0]};
            MD_U16:  a_ext = {{W{1'b0}}, raw_a[W-1:0]};
            default: a_ext = raw_a;
        endcase
    end

    // Magnitudes, result signs and the up-front overflow test.
    always_comb begin
        is_signed = mode_signed(mode);
        a_neg     = is_signed & a_ext[2*W-1];
        b_neg     = is_signed & raw_b[W-1];
        a_mag     = a_neg ? (~a_ext + 1'b1) : a_ext;
        b_mag     = b_neg ? (~raw_b + 1'b1) : raw_b;
        neg_q     = a_neg ^ b_neg;
        neg_r     = a_neg;
        early_err = (raw_b == '0) || (a_mag[2*W-1:W] >= b_mag);
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring division step on unsigned magnitudes: shifts the next
// dividend bit into the partial remainder, subtracts the divisor when
// it fits and shifts the quotient bit in. Assumes rem_in < b_mag.
module sdiv_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] b_mag,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    // Trial subtraction and restore selection.
    always_comb begin
        trial   = {rem_in, quo_in[W-1]};
        diff    = trial - {1'b0, b_mag};
        fits    = trial >= {1'b0, b_mag};
        rem_out = fits ? diff[W-1:0] : trial[W-1:0];
        quo_out = {quo_in[W-2:0], fits};
    end
endmodule

// File: rtl/sdiv_fix.sv
// Sign restoration: negates the magnitude quotient when the operand
// signs differ, gives the remainder the dividend's sign, and checks
// the signed quotient range. Combinational only.
module sdiv_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic         is_signed,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         range_err
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    // Apply signs and test the two's-complement range.
    always_comb begin
        quo       = neg_q ? (~quo_mag + 1'b1) : quo_mag;
        rem       = neg_r ? (~rem_mag + 1'b1) : rem_mag;
        range_err = is_signed && (neg_q ? (quo_mag > HALF) : quo_mag[W-1]);
    end
endmodule

// File: rtl/stepwise_divider.sv
// Sequential multi-mode divider. Step 0 conditions the operands,
// steps 1..W run restoring iterations, and step W+1 restores signs and
// publishes the results with a one-cycle done pulse. The hold input
// stalls the steps. Assumes start is sampled only while idle.
module stepwise_divider import sdiv_pkg::*; #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    input  logic           hold,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           busy,
    output logic           done,
    output logic           err
);
    localparam int NSTEP = W + 2;
    localparam int CW    = $clog2(NSTEP + 1);
    localparam logic [CW-1:0] LAST = CW'(NSTEP - 1);

    logic [2*W-1:0] raw_a;
    logic [W-1:0]   raw_b;
    logic [2:0]     mode_q;
    logic [W-1:0]   rem_q, quo_q, bmag_q;
    logic           nq_q, nr_q, sgn_q, ovf_q;
    logic [CW-1:0]  cnt;
    logic           busy_q, done_q, err_q;
    logic [W-1:0]   q_out, r_out;

    logic [2*W-1:0] p_amag;
    logic [W-1:0]   p_bmag;
    logic           p_nq, p_nr, p_sgn, p_err;
    logic [W-1:0]   s_rem, s_quo;
    logic [W-1:0]   f_quo, f_rem;
    logic           f_rerr;
    logic           advance;

    assign advance = busy_q && !hold;

    sdiv_prep #(.W(W)) u_prep (
        .raw_a(raw_a), .raw_b(raw_b), .mode(mode_q),
        .a_mag(p_amag), .b_mag(p_bmag), .neg_q(p_nq), .neg_r(p_nr),
        .is_signed(p_sgn), .early_err(p_err)
    );

    sdiv_step #(.W(W)) u_step (
        .rem_in(rem_q), .quo_in(quo_q), .b_mag(bmag_q),
        .rem_out(s_rem), .quo_out(s_quo)
    );

    sdiv_fix #(.W(W)) u_fix (
        .quo_mag(quo_q), .rem_mag(rem_q), .neg_q(nq_q), .neg_r(nr_q),
        .is_signed(sgn_q), .quo(f_quo), .rem(f_rem), .range_err(f_rerr)
    );

    // Sequencer: start acceptance, step counting, busy/done/err flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            cnt    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start && mode_legal(mode)) begin
                    busy_q <= 1'b1;
                    cnt    <= '0;
                    err_q  <= 1'b0;
                end else if (start) begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                end
            end else if (advance) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    err_q  <= ovf_q | f_rerr;
                end
            end
        end
    end

    // Operand capture on start and per-step datapath update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_a  <= '0;
            raw_b  <= '0;
            mode_q <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            bmag_q <= '0;
            nq_q   <= 1'b0;
            nr_q   <= 1'b0;
            sgn_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (!busy_q) begin
            if (start && mode_legal(mode)) begin
                raw_a  <= dividend;
                raw_b  <= divisor;
                mode_q <= mode;
            end
        end else if (advance) begin
            if (cnt == '0) begin
                rem_q  <= p_amag[2*W-1:W];
                quo_q  <= p_amag[W-1:0];
                bmag_q <= p_bmag;
                nq_q   <= p_nq;
                nr_q   <= p_nr;
                sgn_q  <= p_sgn;
                ovf_q  <= p_err;
            end else if (cnt <= CW'(W)) begin
                rem_q <= s_rem;
                quo_q <= s_quo;
            end
        end
    end

    // Result registers: written only on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_out <= '0;
            r_out <= '0;
        end else if (advance && cnt == LAST) begin
            q_out <= f_quo;
            r_out <= f_rem;
        end
    end

    assign quotient  = q_out;
    assign remainder = r_out;
    assign busy      = busy_q;
    assign done      = done_q;
    assign err       = err_q;

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hold && cnt == LAST) |=> (done && !busy));
    a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hold) |=> (busy && $stable(cnt) && $stable(rem_q) && $stable(quo_q)));
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(raw_a) && $stable(raw_b) && $stable(mode_q)));
    a_r9_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder)));
    a_r11_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && mode > 3'd4) |=> (done && err && !busy));
endmodule

// File: tb/stepwise_divider_test.sv
// Bench: behavioural cycle model (integer arithmetic, countdown) compared
// with the divider outputs on every clock, away from the active edge.
module stepwise_divider_test;
    logic        clk = 1'b0;
    logic        rst_n, start, hold;
    logic [2:0]  mode;
    logic [31:0] dividend;
    logic [15:0] divisor;
    logic [15:0] quotient, remainder;
    logic        busy, done, err;

    always #5 clk = ~clk;

    stepwise_divider uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .dividend(dividend), .divisor(divisor), .hold(hold),
        .quotient(quotient), .remainder(remainder),
        .busy(busy), .done(done), .err(err)
    );

    int     checks = 0, errors = 0;
    bit     finished = 0;
    longint cyc = 0;
    string  cur_req = "R12";

    // Reference model state.
    bit          m_busy, m_done, m_err, m_valid;
    int          m_left;
    logic [15:0] m_q, m_r, p_q, p_r;
    bit          p_err;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected result from the requirements, using wide integers.
    function automatic void calc(input logic [2:0] md, input logic [31:0] a_in,
                                 input logic [15:0] b_in);
        longint a, b, q, r;
        bit sg;
        case (md)
            3'd0: begin a = longint'($signed(a_in[15:0])) * 32768; b = longint'($signed(b_in)); sg = 1; end
            3'd1: begin a = longint'($signed(a_in)); b = longint'($signed(b_in)); sg = 1; end
            3'd2: begin a = longint'(a_in); b = longint'(b_in); sg = 0; end
            3'd3: begin a = longint'($signed(a_in[15:0])); b = longint'($signed(b_in)); sg = 1; end
            default: begin a = longint'(a_in[15:0]); b = longint'(b_in); sg = 0; end
        endcase
        if (b == 0) begin
            p_err = 1; p_q = 0; p_r = 0;
        end else begin
            q = a / b;
            r = a % b;
            p_err = sg ? (q < -32768 || q > 32767) : (q > 65535);
            p_q = q[15:0];
            p_r = r[15:0];
        end
    endfunction

    // Model update at a clock edge, from the inputs applied before it.
    function automatic void model_edge();
        m_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_left = 0; m_err = 0; m_q = 0; m_r = 0; m_valid = 1;
        end else if (!m_busy) begin
            if (start && mode <= 3'd4) begin
                m_busy = 1; m_left = 18; m_err = 0;
                calc(mode, dividend, divisor);
            end else if (start) begin
                m_done = 1; m_err = 1;
            end
        end else if (!hold) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0; m_done = 1; m_err = p_err;
                if (p_err) m_valid = 0;
                else begin m_q = p_q; m_r = p_r; m_valid = 1; end
            end
        end
    endfunction

    task automatic compare();
        check("R6", "busy", busy, m_busy);
        check("R9", "done", done, m_done);
        check(cur_req, "err", err, m_err);
        if (m_valid && !m_busy) begin
            check(cur_req, "quotient", quotient, m_q);
            check(cur_req, "remainder", remainder, m_r);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    // One operation with a stall pattern indexed by step and an
    // optional stray start at step sb_at (negative: none).
    task automatic run_op(input string req, input logic [2:0] md,
                          input logic [31:0] a, input logic [15:0] b,
                          input logic [31:0] hp, input int sb_at);
        cur_req = req;
        mode = md; dividend = a; divisor = b; start = 1'b1; hold = 1'b0;
        tick();
        start = 1'b0;
        for (int i = 0; i < 200 && m_busy; i++) begin
            hold = hp[i % 32];
            if (i == sb_at) begin
                start = 1'b1; mode = 3'd2; dividend = 32'h0000_0009; divisor = 16'h0;
            end else begin
                start = 1'b0;
            end
            tick();
        end
        start = 1'b0; hold = 1'b0;
        tick();
        tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; hold = 1'b0;
        mode = 3'd0; dividend = '0; divisor = '0;
        m_busy = 0; m_done = 0; m_err = 0; m_valid = 1; m_left = 0;
        m_q = 0; m_r = 0; p_q = 0; p_r = 0; p_err = 0;
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1'b1;
        cur_req = "R12";
        tick();

        // R1 / R3: 32-bit dividends, signed and unsigned.
        run_op("R1", 3'd1, 32'h0001_2345, 16'h0100, 32'h0, -1);
        run_op("R3", 3'd2, 32'hFFFE_0001, 16'hFFFF, 32'h0, -1);
        run_op("R3", 3'd1, 32'hFFFE_7960, 16'h0007, 32'h0, -1);
        run_op("R3", 3'd2, 32'h1234_5678, 16'hABCD, 32'h0, -1);
        // R5: all sign combinations, truncation toward zero.
        run_op("R5", 3'd1, 32'h0000_0007, 16'hFFFE, 32'h0, -1);
        run_op("R5", 3'd1, 32'hFFFF_FFF9, 16'h0002, 32'h0, -1);
        run_op("R5", 3'd1, 32'hFFFF_FFF9, 16'hFFFE, 32'h0, -1);
        run_op("R5", 3'd3, 32'h0000_8000, 16'h0003, 32'h0, -1);
        // R2: Q15 fractions.
        run_op("R2", 3'd0, 32'h0000_2000, 16'h4000, 32'h0, -1);
        run_op("R2", 3'd0, 32'h0000_E000, 16'h4000, 32'h0, -1);
        run_op("R2", 3'd0, 32'h0000_1000, 16'hD000, 32'h0, -1);
        run_op("R2", 3'd0, 32'h0000_C000, 16'h4000, 32'h0, -1);
        // R4: high word carries junk that must not matter.
        run_op("R4", 3'd3, 32'hDEAD_FF9C, 16'h0007, 32'h0, -1);
        run_op("R4", 3'd4, 32'hBEEF_FF9C, 16'h0007, 32'h0, -1);
        run_op("R4", 3'd4, 32'hFFFF_0005, 16'h0009, 32'h0, -1);
        // R10: zero divisor and out-of-range quotients.
        run_op("R10", 3'd1, 32'h0000_0064, 16'h0000, 32'h0, -1);
        run_op("R10", 3'd3, 32'h0000_8000, 16'hFFFF, 32'h0, -1);
        run_op("R10", 3'd2, 32'h0001_0000, 16'h0001, 32'h0, -1);
        run_op("R10", 3'd0, 32'h0000_4000, 16'h4000, 32'h0, -1);
        run_op("R10", 3'd1, 32'h0000_8000, 16'h0001, 32'h0, -1);
        // R11: illegal codes after a good result; results must persist.
        run_op("R1", 3'd2, 32'h0000_0064, 16'h0007, 32'h0, -1);
        run_op("R11", 3'd5, 32'h0000_0064, 16'h0003, 32'h0, -1);
        run_op("R11", 3'd7, 32'h0000_0010, 16'h0002, 32'h0, -1);
        // R7: stalls on first step, last step and scattered.
        run_op("R7", 3'd1, 32'hFFF0_1234, 16'h7FFF, 32'h0000_0001, -1);
        run_op("R7", 3'd1, 32'h0003_0000, 16'h0005, 32'hAAAA_AAAA, -1);
        run_op("R7", 3'd0, 32'h0000_3000, 16'hA000, 32'hFFF0_0F0F, -1);
        begin
            logic [31:0] last_stall;
            last_stall = 32'h0;
            last_stall[17] = 1'b1;
            last_stall[18] = 1'b1;
            run_op("R7", 3'd4, 32'h0000_FFFF, 16'h0010, last_stall, -1);
        end
        // R8: stray start mid-operation, with and without a stall.
        run_op("R8", 3'd1, 32'h0000_1000, 16'h0003, 32'h0, 5);
        run_op("R8", 3'd3, 32'h0000_F000, 16'h0011, 32'h0000_00F0, 6);
        run_op("R8", 3'd2, 32'h00FF_FFFF, 16'h0100, 32'h0, 17);
        // R9: idle cycles keep results stable.
        cur_req = "R9";
        for (int i = 0; i < 5; i++) tick();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule